// File: doc/BRIEF.md
# UART FIFO Control and Status Registers

This block is the register-side logic that sits between a UART's serial shifters and its bus. It holds a receive byte queue and a transmit byte queue, lets software turn queuing on or off, flush either queue with a bit that clears itself, and set trigger levels. It reports queue fill, line status and latched receive errors through read-only words. When queuing is off, a single holding register takes each received byte instead.

The receive shifter delivers bytes through a one-cycle strobe that carries parity and framing flags. A separate strobe marks a break. A break stores a zero byte. The transmit shifter takes bytes from the head of the transmit queue with a one-cycle take strobe. The block sends two registered event pulses toward the interrupt controller: one for each byte it accepts and one for each receive fault. It also drives a level that is high while the transmit queue is at or below its trigger level. The register port is word-indexed. Read data is combinational from current state, and read side effects take place at the clock edge that ends the read cycle.

Top module: `uart_fifo_regs`

## Requirements
- R1: The FIFO control word sits at index 0. Bit 0 enables queuing, bits [6:4] hold the receive trigger and bits [10:8] hold the transmit trigger, and each reads back as written. Writing 1 to bit 1 empties the receive queue and writing 1 to bit 2 empties the transmit queue. Both of these bits read back as 0, and so does every other bit.
- R2: The FIFO status word sits at index 3. Bits [7:0] hold the receive count, bit 8 is receive full, bits [23:16] hold the transmit count and bit 24 is transmit full. When the receive queue is full, bits [7:0] read 0 and bit 8 reads 1.
- R3: With queuing on, a read of index 5 returns the oldest stored receive byte and removes it. Bit 0 of the line status word is 1 exactly while the receive queue is not empty.
- R4: With queuing on, a read of index 5 while the receive queue is empty returns 0 and pulses `evt_err` in the next cycle.
- R5: A received byte that finds the receive queue full is dropped. The queue contents stay unchanged, error bit 0 (overrun) is set and `evt_err` pulses.
- R6: A break strobe stores a zero byte and sets error bit 3. A byte strobe with the parity flag sets error bit 1, and one with the framing flag sets error bit 2.
- R7: The error word sits at index 2. It reads its accumulated bits and then clears in the same cycle, keeping any error that arrives in that cycle. Bit 9 of the FIFO status word is 1 while any error bit is held.
- R8: The line status word sits at index 1. Bit 0 is receive data ready, bit 1 is transmit queue empty, and bit 2 is transmit queue empty with the transmit line idle. It reads 0x6 after reset.
- R9: With queuing off, each received byte goes into one holding register and sets data ready. A read of index 5 returns the holding register and clears data ready. A byte that arrives while data ready is still set sets the overrun bit.
- R10: A write to index 4 queues the low byte for transmit. A write to a full queue is dropped, and with queuing off a write is accepted only when the queue is empty. `tx_valid` and `tx_data` show the head, `tx_take` removes it, and `tx_low` is high while queuing is on and the transmit count is at most the transmit trigger times TRIG_SCALE.
- R11: Writes to indexes 1, 2, 3 and 5 change no state. `evt_rx` pulses once, in the cycle after each byte or break the block accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity fault flag for the received byte |
| rx_frame_err | input | 1 | Framing fault flag for the received byte |
| rx_break | input | 1 | Break detected strobe |
| tx_take | input | 1 | Transmit shifter takes the head byte |
| tx_line_busy | input | 1 | Transmit shifter is sending a byte |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_low | output | 1 | Transmit queue at or below trigger |
| evt_rx | output | 1 | Pulse: a byte was accepted |
| evt_err | output | 1 | Pulse: overrun or empty-queue read |

## Verification
The bench builds the block with DEPTH set to 4 and TRIG_SCALE set to 1. With that depth the receive and transmit queues fill after four bytes. Full-queue reporting, dropped bytes and overrun are then covered by both the directed part and most of the random sequence. A scale of 1 makes the transmit trigger field compare directly against a count that crosses it within a few writes.

// File: rtl/ufr_pkg.sv
// Shared register indexes and bit positions for the UART FIFO register block.
package ufr_pkg;
    typedef enum logic [2:0] {
        A_FCTL   = 3'd0,
        A_TRSTAT = 3'd1,
        A_ERR    = 3'd2,
        A_FSTAT  = 3'd3,
        A_TXD    = 3'd4,
        A_RXD    = 3'd5
    } ufr_addr_e;

    localparam int FC_EN    = 0;
    localparam int FC_RXRST = 1;
    localparam int FC_TXRST = 2;

    localparam int ERR_W    = 4;
    localparam int E_OVR    = 0;
    localparam int E_PAR    = 1;
    localparam int E_FRM    = 2;
    localparam int E_BRK    = 3;
endpackage

// File: rtl/ufr_byte_fifo.sv
// Circular byte queue with flush. Assumes DEPTH >= 2. A push into a full
// queue is accepted only when a pop happens in the same cycle. Flush wins
// over push and pop.
module ufr_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    // Store the incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !clr |=> count == $past(count));
    p_flush_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/ufr_err_latch.sv
// Sticky receive error bits that clear when read. An error that arrives in
// the read cycle is kept for the next read.
module ufr_err_latch
    import ufr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_clr,
    input  logic [ERR_W-1:0] set,
    output logic [ERR_W-1:0] err_q
);
    // Accumulate new errors and drop the old ones on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (rd_clr ? '0 : err_q) | set;
    end

    p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr && (set == '0) |=> err_q == '0);
endmodule

// File: rtl/uart_fifo_regs.sv
// FIFO control, status and error registers of a UART, with receive and
// transmit byte queues and the holding register used when queuing is off.
// Assumes DEPTH <= 255 so that the counts fit their 8-bit status fields.
module uart_fifo_regs
    import ufr_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TRIG_SCALE = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_parity_err,
    input  logic        rx_frame_err,
    input  logic        rx_break,
    input  logic        tx_take,
    input  logic        tx_line_busy,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_low,
    output logic        evt_rx,
    output logic        evt_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             fen_q;
    logic [2:0]       rxtrig_q, txtrig_q;
    logic [7:0]       hold_q;
    logic             hready_q;
    logic             wr_fctl, wr_tx, rd_rx, rd_err;
    logic             rx_clr, tx_clr, rx_in, rx_push, rx_pop, rx_drop;
    logic             hold_ovr, empty_rd, tx_push, rx_ready;
    logic [7:0]       rx_in_byte, rx_dout;
    logic [CW-1:0]    rx_count, tx_count;
    logic             rx_full, rx_empty, tx_full, tx_empty;
    logic [ERR_W-1:0] err_set, err_q;
    logic [31:0]      fstat, trstat;

    assign wr_fctl    = reg_wr && (reg_addr == A_FCTL);
    assign wr_tx      = reg_wr && (reg_addr == A_TXD);
    assign rd_rx      = reg_rd && (reg_addr == A_RXD);
    assign rd_err     = reg_rd && (reg_addr == A_ERR);
    assign rx_clr     = wr_fctl && reg_wdata[FC_RXRST];
    assign tx_clr     = wr_fctl && reg_wdata[FC_TXRST];
    assign rx_in      = rx_valid || rx_break;
    assign rx_in_byte = rx_break ? 8'h00 : rx_byte;
    assign rx_push    = fen_q && rx_in;
    assign rx_pop     = fen_q && rd_rx;
    assign rx_drop    = fen_q && rx_in && rx_full && !(rd_rx && !rx_empty);
    assign empty_rd   = fen_q && rd_rx && rx_empty;
    assign hold_ovr   = !fen_q && rx_in && hready_q && !rd_rx;
    assign tx_push    = wr_tx && (fen_q || tx_empty);

    ufr_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
        .din(rx_in_byte), .dout(rx_dout), .count(rx_count),
        .full(rx_full), .empty(rx_empty));

    ufr_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_take),
        .din(reg_wdata[7:0]), .dout(tx_data), .count(tx_count),
        .full(tx_full), .empty(tx_empty));

    assign err_set[E_OVR] = rx_drop || hold_ovr;
    assign err_set[E_PAR] = rx_valid && rx_parity_err;
    assign err_set[E_FRM] = rx_valid && rx_frame_err;
    assign err_set[E_BRK] = rx_break;

    ufr_err_latch u_err (
        .clk(clk), .rst_n(rst_n), .rd_clr(rd_err), .set(err_set), .err_q(err_q));

    // Control fields; the two flush bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fen_q    <= 1'b0;
            rxtrig_q <= '0;
            txtrig_q <= '0;
        end else if (wr_fctl) begin
            fen_q    <= reg_wdata[FC_EN];
            rxtrig_q <= reg_wdata[6:4];
            txtrig_q <= reg_wdata[10:8];
        end
    end

    // Holding register used while queuing is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            hready_q <= 1'b0;
        end else if (!fen_q && rx_in) begin
            hold_q   <= rx_in_byte;
            hready_q <= 1'b1;
        end else if (!fen_q && rd_rx) begin
            hready_q <= 1'b0;
        end
    end

    // Registered event pulses toward the interrupt logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_rx  <= 1'b0;
            evt_err <= 1'b0;
        end else begin
            evt_rx  <= fen_q ? (rx_in && !rx_drop && !rx_clr) : rx_in;
            evt_err <= rx_drop || hold_ovr || empty_rd;
        end
    end

    assign rx_ready = fen_q ? !rx_empty : hready_q;
    assign tx_valid = !tx_empty;
    assign tx_low   = fen_q && (int'(tx_count) <= int'(txtrig_q) * TRIG_SCALE);
    assign trstat   = {29'd0, tx_empty && !tx_line_busy, tx_empty, rx_ready};
    assign fstat    = {7'd0, tx_full, 8'(tx_count), 6'd0, (err_q != '0),
                       rx_full, rx_full ? 8'd0 : 8'(rx_count)};

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            A_FCTL:   reg_rdata = {21'd0, txtrig_q, 1'b0, rxtrig_q, 3'b000, fen_q};
            A_TRSTAT: reg_rdata = trstat;
            A_ERR:    reg_rdata = {28'd0, err_q};
            A_FSTAT:  reg_rdata = fstat;
            A_RXD:    reg_rdata = fen_q ? (rx_empty ? 32'd0 : {24'd0, rx_dout})
                                        : {24'd0, hold_q};
            default:  reg_rdata = 32'd0;
        endcase
    end

    p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rx && fen_q && !trstat[0] |-> reg_rdata == 32'd0);
    p_break_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break && fen_q && !rx_full && !rx_clr |=> !rx_empty);
    p_full_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH)) |-> fstat[8] && (fstat[7:0] == 8'd0));
endmodule

// File: tb/tb_uart_fifo_regs.sv
module tb_uart_fifo_regs;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 0, rx_parity_err = 0, rx_frame_err = 0, rx_break = 0;
    logic [7:0]  rx_byte = 0;
    logic        tx_take = 0, tx_line_busy = 0;
    logic        tx_valid, tx_low, evt_rx, evt_err;
    logic [7:0]  tx_data;

    int checks = 0, errors = 0;
    logic [7:0] rxq[$], txq[$];
    logic [3:0] merr = 0;

    uart_fifo_regs #(.DEPTH(D), .TRIG_SCALE(1)) dut (.*);

    always #2 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_fstat();
        logic [31:0] v = 0;
        v[7:0]   = (rxq.size() == D) ? 8'd0 : 8'(rxq.size());
        v[8]     = (rxq.size() == D);
        v[9]     = (merr != 0);
        v[23:16] = 8'(txq.size());
        v[24]    = (txq.size() == D);
        return v;
    endfunction

    function automatic logic [31:0] exp_trstat();
        return {29'd0, txq.size() == 0, txq.size() == 0, rxq.size() != 0};
    endfunction

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rxb(input logic [7:0] b, input logic brk, input logic par, input logic frm);
        rx_valid = !brk; rx_break = brk; rx_byte = b;
        rx_parity_err = par; rx_frame_err = frm;
        @(negedge clk);
        rx_valid = 0; rx_break = 0; rx_parity_err = 0; rx_frame_err = 0;
    endtask

    task automatic take();
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset values
        rd(3'd1, d); chk("R8 reset trstat", d, 32'h6);
        rd(3'd3, d); chk("R2 reset fstat", d, 32'h0);
        rd(3'd0, d); chk("R1 reset fctl", d, 32'h0);
        // R1: fields read back, flush bits and stray bits read 0
        wr(3'd0, 32'h0000_8357);
        rd(3'd0, d); chk("R1 fctl readback", d, 32'h351);
        // R3 / R11: fill, evt_rx per byte
        for (int i = 0; i < D; i++) begin
            rxb(8'h10 + 8'(i), 0, 0, 0);
            chk("R11 evt_rx pulse", evt_rx, 1);
            rxq.push_back(8'h10 + 8'(i));
        end
        rd(3'd3, d); chk("R2 full reads count 0", d, 32'h100);
        // R5: overflow drop
        rxb(8'hEE, 0, 0, 0); merr[0] = 1;
        chk("R5 evt_err on drop", evt_err, 1);
        chk("R5 no evt_rx on drop", evt_rx, 0);
        rd(3'd3, d); chk("R7 fstat error bit", d, 32'h300);
        rd(3'd2, d); chk("R5 overrun bit", d, 32'h1);
        rd(3'd2, d); chk("R7 cleared on read", d, 32'h0); merr = 0;
        // R11: writes to read-only indexes ignored
        wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'hF); wr(3'd3, 32'hFFFF_FFFF); wr(3'd5, 32'hFF);
        rd(3'd3, d); chk("R11 fstat unchanged", d, 32'h100);
        rd(3'd2, d); chk("R11 err unchanged", d, 32'h0);
        // R3: order and data ready
        for (int i = 0; i < D; i++) begin
            rd(3'd5, d); chk("R3 rx order", d, {24'd0, rxq.pop_front()});
        end
        rd(3'd1, d); chk("R3 data ready cleared", d, 32'h6);
        // R4: empty read
        rd(3'd5, d); chk("R4 empty read zero", d, 32'h0);
        chk("R4 evt_err after empty read", evt_err, 1);
        // R6: break and flags
        rxb(8'h55, 1, 0, 0);
        chk("R6 evt_rx on break", evt_rx, 1);
        rd(3'd1, d); chk("R6 break makes data ready", d, 32'h7);
        rd(3'd5, d); chk("R6 break byte zero", d, 32'h0);
        rd(3'd2, d); chk("R6 break bit", d, 32'h8);
        rxb(8'h33, 0, 1, 1);
        rd(3'd2, d); chk("R6 parity and frame bits", d, 32'h6);
        rd(3'd5, d); chk("R6 flagged byte stored", d, 32'h33);
        // R7: error in read cycle is kept
        rx_valid = 1; rx_byte = 8'h44; rx_parity_err = 1;
        rd(3'd2, d);
        rx_valid = 0; rx_parity_err = 0;
        chk("R7 read before new error", d, 32'h0);
        rd(3'd2, d); chk("R7 same-cycle error kept", d, 32'h2);
        rd(3'd5, d); chk("R3 byte with error", d, 32'h44);
        // R1: flush receive queue
        rxb(8'h01, 0, 0, 0);
        wr(3'd0, 32'h0000_0303);
        rd(3'd3, d); chk("R1 rx flush", d, 32'h0);
        rd(3'd0, d); chk("R1 flush bit reads 0", d, 32'h301);
        // R10: transmit path, trigger 3
        wr(3'd4, 32'h1A5);
        #1 chk("R10 tx_valid", tx_valid, 1);
        chk("R10 tx_data", tx_data, 8'hA5);
        chk("R10 tx_low at 1", tx_low, 1);
        rd(3'd1, d); chk("R8 tx not empty", d, 32'h0);
        wr(3'd4, 32'h2); wr(3'd4, 32'h3); wr(3'd4, 32'h4); wr(3'd4, 32'h5);
        #1 chk("R10 tx_low above trigger", tx_low, 0);
        rd(3'd3, d); chk("R10 tx count full", d, 32'h0104_0000);
        take();
        #1 chk("R10 head after take", tx_data, 8'h02);
        tx_line_busy = 1;
        take(); take(); take();
        rd(3'd1, d); chk("R8 line busy", d, 32'h2);
        tx_line_busy = 0;
        // R9: queuing off
        wr(3'd0, 32'h0000_0006);
        #1 chk("R10 tx_low off when disabled", tx_low, 0);
        rxb(8'h3C, 0, 0, 0);
        rd(3'd1, d); chk("R9 hold ready", d, 32'h7);
        rxb(8'h3D, 0, 0, 0);
        rd(3'd2, d); chk("R9 hold overrun", d, 32'h1);
        rd(3'd5, d); chk("R9 hold data", d, 32'h3D);
        rd(3'd1, d); chk("R9 ready cleared", d, 32'h6);
        wr(3'd4, 32'h77); wr(3'd4, 32'h78);
        rd(3'd3, d); chk("R10 one byte when disabled", d, 32'h0001_0000);
        #1 chk("R10 disabled head", tx_data, 8'h77);
        take();
        // random phase, queuing on, flush both
        wr(3'd0, 32'h0000_0007);
        rxq.delete(); txq.delete(); merr = 0;
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [7:0] b;
            op = int'($urandom_range(0, 8));
            b = 8'($urandom);
            case (op)
                0, 1: begin
                    rxb(b, 0, 0, 0);
                    if (rxq.size() < D) rxq.push_back(b); else merr[0] = 1;
                end
                2, 3: begin
                    rd(3'd5, d);
                    chk("R3 random rx read", d, rxq.size() ? {24'd0, rxq.pop_front()} : 32'd0);
                end
                4: begin rd(3'd3, d); chk("R2 random fstat", d, exp_fstat()); end
                5: begin rd(3'd1, d); chk("R8 random trstat", d, exp_trstat()); end
                6: begin
                    wr(3'd4, {24'd0, b});
                    if (txq.size() < D) txq.push_back(b);
                end
                7: begin
                    #1;
                    chk("R10 random tx_valid", tx_valid, txq.size() != 0);
                    if (txq.size() != 0) begin
                        chk("R10 random tx_data", tx_data, txq.pop_front());
                        take();
                    end else @(negedge clk);
                end
                default: begin
                    rd(3'd2, d); chk("R7 random err", d, {28'd0, merr}); merr = 0;
                end
            endcase
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule